// File: doc/BRIEF.md
# Staged Sample Trigger Matcher

This block watches a parallel stream of logic-analyser samples and raises a one-cycle trigger pulse when a programmed condition is met. Each sample carries one bit per channel and is qualified by a valid strobe. Each channel is compared against its own condition, taken from the configuration table of the stage currently being evaluated. A stage is satisfied when every participating channel meets its condition on the same sample. Stages are walked in order, and completing the last one fires the trigger.

The per-channel condition comes from three bits: a mask, a value and an edge select. Together they give don't-care, level-high, level-low, rising, falling or any-transition matching. A global word supplies the number of stages in use and the number of enabled channels. Edge conditions compare each sample with the previous valid sample since arming. Arming with `arm` clears all progress. After one trigger the matcher stays idle until it is armed again. With `trig_en` low it fires on the first accepted sample, which suits free-running captures. Along with the pulse, the block reports the zero-based index of the sample that caused the trigger, counted from arming.

Top module: `trig_stage_matcher`

## Requirements
- R1: After reset `trig_fire` is 0, `trig_idx` is 0 and the matcher is idle: valid samples arriving before the first `arm` never fire.
- R2: A channel with mask 0 and edge 0 is a level condition: it holds when the channel bit equals its value bit (value 1 high, value 0 low).
- R3: A stage holds only when every participating channel meets its condition on the same sample; a channel with mask 1 and edge 0 is don't-care.
- R4: A channel with mask 0 and edge 1 is a directed edge, compared with the previous valid sample: value 1 needs 0 then 1 (rising), value 0 needs 1 then 0 (falling). The first valid sample after arming satisfies no edge condition.
- R5: A channel with mask 1 and edge 1 holds on any change of that channel since the previous valid sample.
- R6: In `cfg_glb`, bits [3:0] give the number of stages (0 counts as 1, values above NSTG count as NSTG) and bits [15:4] give the enabled channel count; channels whose index is not below that count are don't-care.
- R7: Stage s uses bits [s*NCH +: NCH] of the mask, value and edge tables and bits [s*32 +: 32] of `cfg_count`. With count c, the stage is complete after c+1 valid samples that meet it, which need not be consecutive. Completing a non-final stage moves to the next one with a fresh count. Completing the final stage fires.
- R8: Once armed, the matcher fires at most once; after firing it ignores samples until `arm` is pulsed again.
- R9: With `trig_en` low, an armed matcher fires on its first accepted valid sample regardless of the tables.
- R10: Samples with `smp_valid` low, and any sample presented in the same cycle as `arm`, are ignored: they advance no index, count or stage and do not become the previous sample.
- R11: `trig_fire` is high for exactly the one cycle after the clock edge that accepted the firing sample. In that cycle `trig_idx` becomes the zero-based count of samples accepted since arming before the firing one, and it holds that value until the next fire.
- R12: `arm` restarts the search at stage 0 with cleared counts, index and previous sample, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start or restart the trigger search |
| trig_en | input | 1 | 1: evaluate stages; 0: fire on first sample |
| smp_valid | input | 1 | Sample qualifier |
| smp | input | NCH | Channel sample |
| cfg_mask | input | NSTG*NCH | Per-stage mask table (1 = not participating) |
| cfg_value | input | NSTG*NCH | Per-stage value table |
| cfg_edge | input | NSTG*NCH | Per-stage edge-select table |
| cfg_count | input | NSTG*CW | Per-stage extra hit count |
| cfg_glb | input | GW | Enabled channels [15:4], stage count [3:0] |
| trig_fire | output | 1 | Trigger pulse |
| trig_idx | output | IW | Index of the firing sample since arming |

## Verification
On every cycle the assertions check several properties. The trigger is a single-cycle pulse that is always caused by an accepted sample while armed. Firing leaves the matcher disarmed. A disabled trigger fires on the very next accepted sample. The reported index holds between pulses. Arming restarts at stage 0. The cases that depend on data can only be shown by the bench's scenarios, where a behavioural model runs alongside the design on each clock. These cases are the level and edge codes, the rule that the first sample cannot form an edge, channel-count and stage-count decoding, multi-hit stage sequencing and a restart in mid-sequence.

// File: rtl/trig_stage_matcher.sv
module trig_stage_matcher #(
  parameter int NCH  = 16,
  parameter int NSTG = 4,
  parameter int CW   = 32,
  parameter int IW   = 32,
  parameter int GW   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 arm,
  input  logic                 trig_en,
  input  logic                 smp_valid,
  input  logic [NCH-1:0]       smp,
  input  logic [NSTG*NCH-1:0]  cfg_mask,
  input  logic [NSTG*NCH-1:0]  cfg_value,
  input  logic [NSTG*NCH-1:0]  cfg_edge,
  input  logic [NSTG*CW-1:0]   cfg_count,
  input  logic [GW-1:0]        cfg_glb,
  output logic                 trig_fire,
  output logic [IW-1:0]        trig_idx
);

  localparam int SW = (NSTG > 1) ? $clog2(NSTG) : 1;
  localparam int NW = GW - 4;

  logic           armed_q;
  logic           havep_q;
  logic [SW-1:0]  stg_q;
  logic [CW-1:0]  hits_q;
  logic [IW-1:0]  idx_q;
  logic [NCH-1:0] prev_q;
  logic [SW-1:0]  last_stg;
  logic [NCH-1:0] ch_ok;

  wire [NCH-1:0] cm     = cfg_mask [stg_q*NCH +: NCH];
  wire [NCH-1:0] cv     = cfg_value[stg_q*NCH +: NCH];
  wire [NCH-1:0] ce     = cfg_edge [stg_q*NCH +: NCH];
  wire [CW-1:0]  cc     = cfg_count[stg_q*CW +: CW];
  wire [NW-1:0]  en_cnt = cfg_glb[GW-1:4];
  wire [3:0]     n_stg  = cfg_glb[3:0];

  always_comb begin
    if (n_stg == 4'd0)
      last_stg = '0;
    else if (32'(n_stg) > NSTG)
      last_stg = SW'(NSTG - 1);
    else
      last_stg = SW'(n_stg - 4'd1);
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire act = en_cnt > NW'(i);
    wire p   = prev_q[i];
    wire c   = smp[i];
    wire lvl = cm[i] | (c == cv[i]);
    wire edg = havep_q & (cm[i] ? (p ^ c) : (cv[i] ? (c & ~p) : (p & ~c)));
    assign ch_ok[i] = ~act | (ce[i] ? edg : lvl);
  end

  wire stage_hit  = &ch_ok;
  wire take       = armed_q & smp_valid & ~arm;
  wire stage_done = stage_hit & (hits_q == cc);
  wire fire_now   = take & (~trig_en | (stage_done & (stg_q == last_stg)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q   <= 1'b0;
      havep_q   <= 1'b0;
      stg_q     <= '0;
      hits_q    <= '0;
      idx_q     <= '0;
      prev_q    <= '0;
      trig_fire <= 1'b0;
      trig_idx  <= '0;
    end else begin
      trig_fire <= fire_now;
      if (fire_now) trig_idx <= idx_q;
      if (arm) begin
        armed_q <= 1'b1;
        havep_q <= 1'b0;
        stg_q   <= '0;
        hits_q  <= '0;
        idx_q   <= '0;
      end else if (take) begin
        prev_q  <= smp;
        havep_q <= 1'b1;
        idx_q   <= idx_q + IW'(1);
        if (fire_now) begin
          armed_q <= 1'b0;
        end else if (stage_hit) begin
          if (stage_done) begin
            stg_q  <= stg_q + SW'(1);
            hits_q <= '0;
          end else begin
            hits_q <= hits_q + CW'(1);
          end
        end
      end
    end
  end

endmodule

// File: rtl/trig_stage_matcher_chk.sv
module trig_stage_matcher_chk #(
  parameter int SW = 2,
  parameter int IW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          arm,
  input logic          trig_en,
  input logic          smp_valid,
  input logic          armed_q,
  input logic [SW-1:0] stg_q,
  input logic          trig_fire,
  input logic [IW-1:0] trig_idx
);

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |=> !trig_fire); // R8

  AST_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |-> !armed_q); // R8

  AST_FIRE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    trig_fire |-> ($past(smp_valid) && $past(armed_q) && !$past(arm))); // R10

  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && smp_valid && !arm && !trig_en) |=> trig_fire); // R9

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !trig_fire |-> $stable(trig_idx)); // R11

  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (armed_q && stg_q == '0)); // R12

endmodule

bind trig_stage_matcher trig_stage_matcher_chk #(.SW(SW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .trig_en(trig_en),
  .smp_valid(smp_valid), .armed_q(armed_q), .stg_q(stg_q),
  .trig_fire(trig_fire), .trig_idx(trig_idx)
);

// File: tb/trig_stage_matcher_tb.sv
module trig_stage_matcher_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16, NSTG = 4, CW = 32, IW = 32, GW = 16;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, trig_en = 1'b0, smp_valid = 1'b0;
  logic [NCH-1:0] smp = '0;
  logic [NSTG*NCH-1:0] cfg_mask, cfg_value, cfg_edge;
  logic [NSTG*CW-1:0] cfg_count;
  logic [GW-1:0] cfg_glb;
  logic trig_fire;
  logic [IW-1:0] trig_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_arm = 0, m_have = 0;
  int m_stg = 0;
  longint m_hits = 0, m_idx = 0;
  logic [NCH-1:0] m_prev = '0;
  bit e_fire = 0;
  longint e_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_stage_matcher #(.NCH(NCH), .NSTG(NSTG), .CW(CW), .IW(IW), .GW(GW)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm(arm), .trig_en(trig_en), .smp_valid(smp_valid),
    .smp(smp), .cfg_mask(cfg_mask), .cfg_value(cfg_value), .cfg_edge(cfg_edge),
    .cfg_count(cfg_count), .cfg_glb(cfg_glb), .trig_fire(trig_fire), .trig_idx(trig_idx)
  );

  function automatic int last_of(logic [GW-1:0] g);
    int n = int'(g[3:0]);
    if (n == 0) return 0;
    if (n > NSTG) return NSTG - 1;
    return n - 1;
  endfunction

  function automatic bit stage_ok(int s);
    int used = int'(cfg_glb[GW-1:4]);
    for (int i = 0; i < NCH; i++) begin
      bit m = cfg_mask[s*NCH+i], v = cfg_value[s*NCH+i], e = cfg_edge[s*NCH+i];
      bit c = smp[i], p = m_prev[i];
      if (i >= used) continue;
      case ({m, e})
        2'b00: if (c != v) return 0;
        2'b01: if (!m_have || !(v ? (!p && c) : (p && !c))) return 0;
        2'b11: if (!m_have || p == c) return 0;
        default: ;
      endcase
    end
    return 1;
  endfunction

  task automatic model();
    e_fire = 0;
    if (arm) begin
      m_arm = 1; m_stg = 0; m_hits = 0; m_have = 0; m_idx = 0;
    end else if (m_arm && smp_valid) begin
      bit go = 0;
      if (!trig_en) go = 1;
      else if (stage_ok(m_stg)) begin
        if (m_hits == longint'(cfg_count[m_stg*CW +: CW])) begin
          if (m_stg == last_of(cfg_glb)) go = 1;
          else begin m_stg++; m_hits = 0; end
        end else m_hits++;
      end
      if (go) begin e_fire = 1; e_idx = m_idx; m_arm = 0; end
      m_prev = smp; m_have = 1; m_idx++;
    end
  endtask

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit a, bit v, logic [NCH-1:0] s);
    arm = a; smp_valid = v; smp = s;
    model();
    @(posedge clk); #1;
    check(trig_fire === e_fire, cur_req, "trig_fire", longint'(trig_fire), longint'(e_fire));
    check(trig_idx === IW'(e_idx), cur_req, "trig_idx", longint'(trig_idx), e_idx);
    @(negedge clk);
  endtask

  task automatic expect_fire(bit f, longint idx, string req);
    check(trig_fire === f, req, "directed trig_fire", longint'(trig_fire), longint'(f));
    if (f) check(trig_idx === IW'(idx), req, "directed trig_idx", longint'(trig_idx), idx);
  endtask

  task automatic cfg_clear(int nst, int nch);
    cfg_mask = '1; cfg_value = '0; cfg_edge = '0; cfg_count = '0;
    cfg_glb = GW'((nch << 4) | nst);
  endtask

  task automatic set_ch(int s, int ch, bit m, bit v, bit e);
    cfg_mask[s*NCH+ch] = m; cfg_value[s*NCH+ch] = v; cfg_edge[s*NCH+ch] = e;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      n_fail++;
      $display("FAIL %s watchdog: actual 1 expected 0", cur_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_clear(1, 16);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    cur_req = "R1";
    check(trig_fire === 1'b0, "R1", "reset trig_fire", longint'(trig_fire), 0);
    check(trig_idx === '0, "R1", "reset trig_idx", longint'(trig_idx), 0);
    @(negedge clk);
    trig_en = 0;
    repeat (3) cyc(0, 1, 16'h1234);
    expect_fire(0, 0, "R1");

    cur_req = "R9";
    cyc(1, 0, '0); cyc(0, 1, 16'h0000); expect_fire(1, 0, "R9");
    cur_req = "R8";
    repeat (3) begin cyc(0, 1, 16'hFFFF); expect_fire(0, 0, "R8"); end

    cur_req = "R2"; trig_en = 1;
    cfg_clear(1, 16); set_ch(0, 3, 0, 1, 0);
    cyc(1, 0, '0); cyc(0, 1, 16'h0000); expect_fire(0, 0, "R2");
    cyc(0, 1, 16'h0008); expect_fire(1, 1, "R2");
    cfg_clear(1, 16); set_ch(0, 7, 0, 0, 0);
    cyc(1, 0, '0); cyc(0, 1, 16'h0080); cyc(0, 1, 16'hFFFF); expect_fire(0, 0, "R2");
    cyc(0, 1, 16'h0000); expect_fire(1, 2, "R2");

    cur_req = "R3";
    cfg_clear(1, 16); set_ch(0, 1, 0, 1, 0); set_ch(0, 2, 0, 0, 0);
    cyc(1, 0, '0); cyc(0, 1, 16'h0006); expect_fire(0, 0, "R3");
    cyc(0, 1, 16'h0000); expect_fire(0, 0, "R3");
    cyc(0, 1, 16'hFFF2 & 16'hFFFB); expect_fire(1, 2, "R3");

    cur_req = "R4";
    cfg_clear(1, 16); set_ch(0, 5, 0, 1, 1);
    cyc(1, 0, '0); cyc(0, 1, 16'h0020); expect_fire(0, 0, "R4");
    cyc(0, 1, 16'h0020); cyc(0, 1, 16'h0000); expect_fire(0, 0, "R4");
    cyc(0, 1, 16'h0020); expect_fire(1, 3, "R4");
    cfg_clear(1, 16); set_ch(0, 9, 0, 0, 1);
    cyc(1, 0, '0); cyc(0, 1, 16'h0000); cyc(0, 1, 16'h0200); expect_fire(0, 0, "R4");
    cyc(0, 1, 16'h0000); expect_fire(1, 2, "R4");

    cur_req = "R5";
    cfg_clear(1, 16); set_ch(0, 0, 1, 0, 1);
    cyc(1, 0, '0); cyc(0, 1, 16'h0001); cyc(0, 1, 16'h0001); expect_fire(0, 0, "R5");
    cyc(0, 1, 16'h0000); expect_fire(1, 2, "R5");
    cyc(1, 0, '0); cyc(0, 1, 16'h0000); cyc(0, 1, 16'h0001); expect_fire(1, 1, "R5");

    cur_req = "R6";
    cfg_clear(1, 8); set_ch(0, 12, 0, 1, 0);
    cyc(1, 0, '0); cyc(0, 1, 16'h0000); expect_fire(1, 0, "R6");
    cfg_clear(0, 16); set_ch(0, 0, 0, 1, 0); set_ch(1, 0, 0, 0, 0);
    cyc(1, 0, '0); cyc(0, 1, 16'h0001); expect_fire(1, 0, "R6");
    cfg_clear(9, 16); set_ch(3, 4, 0, 1, 0);
    cyc(1, 0, '0); cyc(0, 1, 16'h0000); cyc(0, 1, 16'h0000); cyc(0, 1, 16'h0000);
    expect_fire(0, 0, "R6");
    cyc(0, 1, 16'h0010); expect_fire(1, 3, "R6");

    cur_req = "R7";
    cfg_clear(2, 16); set_ch(0, 0, 0, 1, 0); cfg_count[0 +: CW] = 1; set_ch(1, 1, 0, 1, 1);
    cyc(1, 0, '0); cyc(0, 1, 16'h0001); cyc(0, 1, 16'h0000); cyc(0, 1, 16'h0001);
    expect_fire(0, 0, "R7");
    cyc(0, 1, 16'h0002); expect_fire(1, 3, "R7");

    cur_req = "R12";
    cyc(1, 0, '0); cyc(0, 1, 16'h0001); cyc(0, 1, 16'h0001);
    cyc(1, 0, '0); cyc(0, 1, 16'h0002); expect_fire(0, 0, "R12");

    cur_req = "R10";
    cfg_clear(1, 16); set_ch(0, 0, 0, 1, 1);
    cyc(1, 0, '0); cyc(0, 1, 16'h0000); cyc(0, 0, 16'h0001); cyc(0, 0, 16'h0000);
    expect_fire(0, 0, "R10");
    cyc(0, 1, 16'h0001); expect_fire(1, 1, "R10");
    trig_en = 0;
    cyc(1, 1, 16'h0000); expect_fire(0, 0, "R10");
    cyc(0, 1, 16'h0000); expect_fire(1, 0, "R10");

    cur_req = "R11";
    repeat (4) cyc(0, 1, 16'h00FF);
    check(trig_idx === IW'(0), "R11", "held trig_idx", longint'(trig_idx), 0);

    cur_req = "R7";
    for (int k = 0; k < 6000; k++) begin
      bit a = ($urandom_range(0, 24) == 0);
      if (a) begin
        cfg_glb = GW'(($urandom_range(0, 16) << 4) | $urandom_range(0, 6));
        trig_en = ($urandom_range(0, 9) != 0);
        for (int s = 0; s < NSTG; s++) begin
          cfg_count[s*CW +: CW] = CW'($urandom_range(0, 2));
          for (int ch = 0; ch < NCH; ch++) begin
            int r = $urandom_range(0, 11);
            case (r)
              6: set_ch(s, ch, 0, 1'($urandom), 0);
              7: set_ch(s, ch, 0, 1'($urandom), 1);
              8: set_ch(s, ch, 1, 0, 1);
              default: set_ch(s, ch, 1, 0, 0);
            endcase
          end
        end
      end
      cyc(a, ($urandom_range(0, 9) < 7), smp ^ NCH'($urandom & $urandom & $urandom));
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule